// File: doc/BRIEF.md
# Monochrome Page-Column Packer

This block turns a rectangular region of a one-bit-per-pixel, row-major frame memory into the byte stream a page-organised monochrome display controller expects. The display is divided into horizontal bands eight pixels tall, called pages. Each output data byte covers one column of one page: bit 0 is the top pixel of the band and bit 7 is the bottom pixel. Before the data, the block sends the addressing commands the controller needs. Their framing depends on which addressing mode is selected.

A request latches the rectangle, the display height, the column and page offsets and the mode. The block snaps the rectangle's top edge to a page boundary, extends the bottom edge to the next page boundary and limits it to the display height. It then reads the frame memory through a synchronous read port with one cycle of latency, transposes the pixels, and streams command and data bytes out over a valid/ready handshake. A command/data flag goes with each byte. A clear request sends a full-screen update of zero bytes and does not touch the memory. The rectangle is given as half-open bounds and must be non-empty. The display height must lie between 1 and `MAX_H`.

Top module: `mono_page_packer`

## Requirements
- R1: Data byte j of page i carries frame column (first column + j). Its bit k is the pixel at row (aligned top + 8*i + k), with bit 0 at the top. A lit pixel is a 1.
- R2: The pixel at row r and column c is read as bit (c mod 8) of frame-memory byte r*ceil(DISP_W/8) + floor(c/8). The read data arrives one cycle after `fb_rd_en`.
- R3: The rectangle top is rounded down to a multiple of 8. The bottom is rounded up to a multiple of 8 and then limited to `disp_height`. One page is sent for every 8 rows in between.
- R4: In a page that reaches past `disp_height`, only the low (height mod 8) bits carry pixels. The bits above them are 0.
- R5: In horizontal mode (`page_mode`=0), the stream is: command bytes 0x21, start column, end column; then 0x22, start page, end page; then every data byte of every page, page by page, as one burst. Command bytes have `tx_is_cmd`=1 and data bytes have `tx_is_cmd`=0.
- R6: In horizontal mode, the three-byte column-range command is left out when its start and end equal those last sent. The page-range command is left out on the same rule.
- R7: In page mode (`page_mode`=1), each page is preceded by 0xB0 with the page address in bits 2:0, then 0x00 with the start column's low nibble, then 0x10 with its high nibble. That page's data bytes follow.
- R8: `col_offset` is added to every column address and `page_offset` to every page address sent. Arithmetic is modulo 256.
- R9: A clear request sends a full-screen update (columns 0 to DISP_W-1, rows 0 to `disp_height`-1) in which every data byte is 0. `fb_rd_en` stays low throughout.
- R10: After reset, the stream is idle and the remembered ranges are invalid, so the first horizontal update always sends both range commands.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_is_cmd` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_req | input | 1 | Start an update of the given rectangle (sampled when idle) |
| clr_req | input | 1 | Start a full-screen clear (sampled when idle, wins over upd_req) |
| rect_x0 | input | XW | First column of the rectangle |
| rect_x1 | input | XW | Column one past the last |
| rect_y0 | input | YW | First row of the rectangle |
| rect_y1 | input | YW | Row one past the last |
| disp_height | input | YW | Display height in rows |
| col_offset | input | 8 | Added to column addresses |
| page_offset | input | 8 | Added to page addresses (usually 1) |
| page_mode | input | 1 | 1 selects per-page position framing, 0 selects window framing |
| busy | output | 1 | High from the cycle after a request until the last byte is accepted |
| fb_rd_en | output | 1 | Frame-memory read strobe |
| fb_rd_addr | output | AW | Frame-memory byte address |
| fb_rd_data | input | 8 | Frame-memory data, valid one cycle after the strobe |
| tx_data | output | 8 | Output byte |
| tx_is_cmd | output | 1 | 1 marks a command byte, 0 a data byte |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Sink accepts the byte |

## Verification
The bench aims at four kinds of fault. A rectangle that starts and ends mid-page catches rounding errors, which would send the wrong number of pages or rows shifted by a few lines. A display height that is not a multiple of 8 catches a packer that reads rows past the screen, which would leave stray bits above the valid rows. Repeated rectangles, with only one range changed between them, exercise the skip logic: a broken cache either resends commands or drops ones that are needed. A reset between two identical requests shows whether the cache is invalidated. Page-mode runs with an offset column above 15 catch swapped or missing column nibbles. Runs where the sink stalls catch output bytes that change while they wait to be accepted.

// File: rtl/mpp_pkg.sv
// Shared constants and state type for the page-column packer.
package mpp_pkg;
    localparam logic [7:0] OP_COL_RANGE  = 8'h21;
    localparam logic [7:0] OP_PAGE_RANGE = 8'h22;
    localparam logic [7:0] OP_PAGE_SEL   = 8'hB0;
    localparam logic [7:0] OP_COL_LO     = 8'h00;
    localparam logic [7:0] OP_COL_HI     = 8'h10;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PLAN, ST_WIN_COL, ST_WIN_PAGE, ST_POS, ST_FETCH, ST_SEND
    } mpp_state_t;
endpackage

// File: rtl/mpp_rect_norm.sv
// Rectangle normaliser: picks the full screen for a clear, snaps the top edge
// down to a page boundary, snaps the bottom edge up to one and limits it to
// the display height. Purely combinational.
// Assumes x1 > x0, y1 > y0 and 1 <= height.
module mpp_rect_norm #(
    parameter int DISP_W = 32,
    parameter int XW     = 6,
    parameter int YW     = 6
) (
    input  logic          full,
    input  logic [XW-1:0] x0,
    input  logic [XW-1:0] x1,
    input  logic [YW-1:0] y0,
    input  logic [YW-1:0] y1,
    input  logic [YW-1:0] height,
    output logic [XW-1:0] col_first,
    output logic [XW-1:0] ncols,
    output logic [YW-1:0] row_top,
    output logic [YW-1:0] npages
);
    logic [XW-1:0] xb;
    logic [YW-1:0] ya, yb;
    logic [YW:0]   bot_up, bot, span;

    // Select the region, then align it to pages.
    always_comb begin
        col_first = full ? '0 : x0;
        xb        = full ? XW'(DISP_W) : x1;
        ya        = full ? '0 : y0;
        yb        = full ? height : y1;
        ncols     = xb - col_first;
        row_top   = ya & ~YW'(7);
        bot_up    = ({1'b0, yb} + (YW+1)'(7)) & ~(YW+1)'(7);
        bot       = (bot_up > {1'b0, height}) ? {1'b0, height} : bot_up;
        span      = bot - {1'b0, row_top} + (YW+1)'(7);
        npages    = YW'(span >> 3);
    end
endmodule

// File: rtl/mpp_col_gather.sv
// Column gatherer: builds one output byte by reading nbits rows of a single
// column, one read per cycle, from a synchronous frame memory with one cycle of
// latency. In zero mode it makes no reads and returns 0 one cycle after go.
// Assumes row0, col and nbits stay stable from go until done.
module mpp_col_gather #(
    parameter int PITCH = 4,
    parameter int AW    = 8,
    parameter int XW    = 6,
    parameter int YW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          zero,
    input  logic [YW-1:0] row0,
    input  logic [XW-1:0] col,
    input  logic [3:0]    nbits,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data,
    output logic          done,
    output logic [7:0]    byte_out
);
    logic       active, pend;
    logic [3:0] k;
    logic [2:0] pend_k;

    // Read request for row k of the current column.
    always_comb begin
        rd_en   = active && (k < nbits);
        rd_addr = AW'((int'(row0) + int'(k)) * PITCH + (int'(col) >> 3));
    end

    // Issue the reads, collect the returned bits and flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            pend     <= 1'b0;
            k        <= '0;
            pend_k   <= '0;
            byte_out <= '0;
            done     <= 1'b0;
        end else begin
            done   <= 1'b0;
            pend   <= rd_en;
            pend_k <= k[2:0];
            if (pend) byte_out[pend_k] <= rd_data[col[2:0]];
            if (go) begin
                byte_out <= '0;
                k        <= '0;
                pend     <= 1'b0;
                active   <= !zero;
                done     <= zero;
            end else if (active) begin
                if (rd_en) begin
                    k <= k + 4'd1;
                end else if (!pend) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    // R4
    zero_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((byte_out & ~((8'h1 << nbits) - 8'h1)) == 8'h0));
    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/mono_page_packer.sv
// Monochrome page-column packer: latches a request and emits the window or
// per-page position commands, then the transposed column bytes of each page.
// It remembers the last column and page ranges sent so that unchanged window
// commands are left out. Assumes 1 <= disp_height <= MAX_H and DISP_W <= 256.
module mono_page_packer
    import mpp_pkg::*;
#(
    parameter int DISP_W = 32,
    parameter int MAX_H  = 40,
    localparam int PITCH = (DISP_W + 7) / 8,
    localparam int DEPTH = MAX_H * PITCH,
    localparam int AW    = $clog2(DEPTH),
    localparam int XW    = $clog2(DISP_W + 1),
    localparam int YW    = $clog2(MAX_H + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_req,
    input  logic          clr_req,
    input  logic [XW-1:0] rect_x0,
    input  logic [XW-1:0] rect_x1,
    input  logic [YW-1:0] rect_y0,
    input  logic [YW-1:0] rect_y1,
    input  logic [YW-1:0] disp_height,
    input  logic [7:0]    col_offset,
    input  logic [7:0]    page_offset,
    input  logic          page_mode,
    output logic          busy,
    output logic          fb_rd_en,
    output logic [AW-1:0] fb_rd_addr,
    input  logic [7:0]    fb_rd_data,
    output logic [7:0]    tx_data,
    output logic          tx_is_cmd,
    output logic          tx_valid,
    input  logic          tx_ready
);
    mpp_state_t    state;
    logic [XW-1:0] x0_q, x1_q, col_first, ncols, cj, col_abs;
    logic [YW-1:0] y0_q, y1_q, h_q, row_top, npages, pg, r0, rem;
    logic [7:0]    coff_q, poff_q, cs, ce, ps, pe, pgaddr, gbyte;
    logic          pmode_q, zero_q, go_q, g_done;
    logic [1:0]    idx;
    logic [3:0]    nbits;
    logic          cc_ok, pc_ok, col_hit, page_hit, last_col, last_page;
    logic [7:0]    cc_s, cc_e, pc_s, pc_e;

    mpp_rect_norm #(.DISP_W(DISP_W), .XW(XW), .YW(YW)) u_norm (
        .full(zero_q), .x0(x0_q), .x1(x1_q), .y0(y0_q), .y1(y1_q),
        .height(h_q), .col_first(col_first), .ncols(ncols),
        .row_top(row_top), .npages(npages)
    );

    // Addresses, current page geometry and cache comparison.
    always_comb begin
        cs        = coff_q + 8'(col_first);
        ce        = cs + 8'(ncols) - 8'd1;
        ps        = poff_q + 8'(row_top >> 3);
        pe        = ps + 8'(npages) - 8'd1;
        pgaddr    = ps + 8'(pg);
        r0        = row_top + YW'({pg, 3'b000});
        rem       = h_q - r0;
        nbits     = (rem >= YW'(8)) ? 4'd8 : rem[3:0];
        col_abs   = col_first + cj;
        col_hit   = cc_ok && (cc_s == cs) && (cc_e == ce);
        page_hit  = pc_ok && (pc_s == ps) && (pc_e == pe);
        last_col  = (cj == ncols - XW'(1));
        last_page = (pg == npages - YW'(1));
    end

    mpp_col_gather #(.PITCH(PITCH), .AW(AW), .XW(XW), .YW(YW)) u_gather (
        .clk(clk), .rst_n(rst_n), .go(go_q), .zero(zero_q), .row0(r0),
        .col(col_abs), .nbits(nbits), .rd_en(fb_rd_en), .rd_addr(fb_rd_addr),
        .rd_data(fb_rd_data), .done(g_done), .byte_out(gbyte)
    );

    // Output byte for the current state and command index.
    always_comb begin
        tx_valid  = (state == ST_WIN_COL) || (state == ST_WIN_PAGE) ||
                    (state == ST_POS) || (state == ST_SEND);
        tx_is_cmd = (state != ST_SEND);
        busy      = (state != ST_IDLE);
        tx_data   = gbyte;
        case (state)
            ST_WIN_COL:  tx_data = (idx == 2'd0) ? OP_COL_RANGE  : (idx == 2'd1) ? cs : ce;
            ST_WIN_PAGE: tx_data = (idx == 2'd0) ? OP_PAGE_RANGE : (idx == 2'd1) ? ps : pe;
            ST_POS: begin
                if (idx == 2'd0)      tx_data = OP_PAGE_SEL | {5'b0, pgaddr[2:0]};
                else if (idx == 2'd1) tx_data = OP_COL_LO | {4'b0, cs[3:0]};
                else                  tx_data = OP_COL_HI | {4'b0, cs[7:4]};
            end
            default: ;
        endcase
    end

    // Capture the request parameters when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {x0_q, x1_q, y0_q, y1_q, h_q} <= '0;
            {coff_q, poff_q}              <= '0;
            pmode_q                       <= 1'b0;
            zero_q                        <= 1'b0;
        end else if (state == ST_IDLE && (upd_req || clr_req)) begin
            x0_q    <= rect_x0;
            x1_q    <= rect_x1;
            y0_q    <= rect_y0;
            y1_q    <= rect_y1;
            h_q     <= disp_height;
            coff_q  <= col_offset;
            poff_q  <= page_offset;
            pmode_q <= page_mode;
            zero_q  <= clr_req;
        end
    end

    // Remember the window ranges once their last byte is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc_ok <= 1'b0;
            pc_ok <= 1'b0;
            {cc_s, cc_e, pc_s, pc_e} <= '0;
        end else if (tx_ready && idx == 2'd2) begin
            if (state == ST_WIN_COL) begin
                cc_ok <= 1'b1;
                cc_s  <= cs;
                cc_e  <= ce;
            end
            if (state == ST_WIN_PAGE) begin
                pc_ok <= 1'b1;
                pc_s  <= ps;
                pc_e  <= pe;
            end
        end
    end

    // Sequencer for command framing and the page/column walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
            pg    <= '0;
            cj    <= '0;
            go_q  <= 1'b0;
        end else begin
            go_q <= 1'b0;
            case (state)
                ST_IDLE: if (upd_req || clr_req) state <= ST_PLAN;
                ST_PLAN: begin
                    idx <= '0;
                    pg  <= '0;
                    cj  <= '0;
                    if (pmode_q)        state <= ST_POS;
                    else if (!col_hit)  state <= ST_WIN_COL;
                    else if (!page_hit) state <= ST_WIN_PAGE;
                    else begin
                        state <= ST_FETCH;
                        go_q  <= 1'b1;
                    end
                end
                ST_WIN_COL: if (tx_ready) begin
                    if (idx == 2'd2) begin
                        idx <= '0;
                        if (!page_hit) state <= ST_WIN_PAGE;
                        else begin
                            state <= ST_FETCH;
                            go_q  <= 1'b1;
                        end
                    end else idx <= idx + 2'd1;
                end
                ST_WIN_PAGE, ST_POS: if (tx_ready) begin
                    if (idx == 2'd2) begin
                        idx   <= '0;
                        state <= ST_FETCH;
                        go_q  <= 1'b1;
                    end else idx <= idx + 2'd1;
                end
                ST_FETCH: if (g_done) state <= ST_SEND;
                ST_SEND: if (tx_ready) begin
                    if (last_col) begin
                        cj <= '0;
                        if (last_page) state <= ST_IDLE;
                        else begin
                            pg <= pg + YW'(1);
                            if (pmode_q) state <= ST_POS;
                            else begin
                                state <= ST_FETCH;
                                go_q  <= 1'b1;
                            end
                        end
                    end else begin
                        cj    <= cj + XW'(1);
                        state <= ST_FETCH;
                        go_q  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R11
    hold_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_is_cmd)));
    // R9
    clr_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && zero_q) |-> !fb_rd_en);
    // R2
    rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_rd_en |-> (int'(fb_rd_addr) < DEPTH));
endmodule

// File: tb/mono_page_packer_tb.sv
module mono_page_packer_tb;
    localparam int DISP_W = 32;
    localparam int MAX_H  = 40;
    localparam int PITCH  = (DISP_W + 7) / 8;
    localparam int DEPTH  = MAX_H * PITCH;
    localparam int AW     = $clog2(DEPTH);
    localparam int XW     = $clog2(DISP_W + 1);
    localparam int YW     = $clog2(MAX_H + 1);

    typedef struct packed {
        logic [XW-1:0] x0;
        logic [XW-1:0] x1;
        logic [YW-1:0] y0;
        logic [YW-1:0] y1;
        logic [YW-1:0] h;
        logic          mode;
        logic [7:0]    coff;
        logic [7:0]    poff;
        logic          stall;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{6'd0, 6'd32, 6'd0,  6'd32, 6'd32, 1'b0, 8'd0,  8'd1, 1'b0},
        '{6'd5, 6'd13, 6'd3,  6'd11, 6'd32, 1'b0, 8'd0,  8'd1, 1'b1},
        '{6'd5, 6'd13, 6'd3,  6'd11, 6'd32, 1'b0, 8'd0,  8'd1, 1'b0},
        '{6'd5, 6'd13, 6'd16, 6'd24, 6'd32, 1'b0, 8'd0,  8'd1, 1'b0},
        '{6'd0, 6'd32, 6'd10, 6'd20, 6'd20, 1'b0, 8'd0,  8'd1, 1'b1},
        '{6'd3, 6'd19, 6'd0,  6'd20, 6'd20, 1'b1, 8'd0,  8'd1, 1'b1},
        '{6'd3, 6'd10, 6'd8,  6'd16, 6'd32, 1'b1, 8'd18, 8'd5, 1'b0},
        '{6'd0, 6'd8,  6'd0,  6'd8,  6'd32, 1'b0, 8'd4,  8'd3, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          upd_req = 1'b0, clr_req = 1'b0;
    logic [XW-1:0] rect_x0 = '0, rect_x1 = '0;
    logic [YW-1:0] rect_y0 = '0, rect_y1 = '0, disp_height = '0;
    logic [7:0]    col_offset = '0, page_offset = '0;
    logic          page_mode = 1'b0;
    logic          busy, fb_rd_en, tx_is_cmd, tx_valid;
    logic          tx_ready = 1'b1;
    logic [AW-1:0] fb_rd_addr;
    logic [7:0]    fb_rd_data, tx_data;

    logic [7:0] fb [DEPTH];
    logic [8:0] exp_q [$];
    logic [8:0] got_q [$];
    int checks = 0, errors = 0, rd_cnt = 0, cyc = 0;
    bit stall_on = 1'b0, finished = 1'b0;
    bit m_cok = 1'b0, m_pok = 1'b0;
    int m_cs, m_ce, m_ps, m_pe;

    always #10 clk = ~clk;

    mono_page_packer #(.DISP_W(DISP_W), .MAX_H(MAX_H)) u_dut (
        .clk(clk), .rst_n(rst_n), .upd_req(upd_req), .clr_req(clr_req),
        .rect_x0(rect_x0), .rect_x1(rect_x1), .rect_y0(rect_y0), .rect_y1(rect_y1),
        .disp_height(disp_height), .col_offset(col_offset), .page_offset(page_offset),
        .page_mode(page_mode), .busy(busy), .fb_rd_en(fb_rd_en), .fb_rd_addr(fb_rd_addr),
        .fb_rd_data(fb_rd_data), .tx_data(tx_data), .tx_is_cmd(tx_is_cmd),
        .tx_valid(tx_valid), .tx_ready(tx_ready)
    );

    // Synchronous frame memory model with one cycle of read latency.
    always @(posedge clk) if (fb_rd_en) fb_rd_data <= fb[fb_rd_addr];

    initial for (int a = 0; a < DEPTH; a++) fb[a] = 8'((a * 37 + 11) ^ (a >> 2) ^ (a * 5));

    function automatic string tag_of(input int i);
        case (i)
            0: return "R2"; 1: return "R3"; 2: return "R6"; 3: return "R6";
            4: return "R4"; 5: return "R7"; 6: return "R8"; default: return "R1";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int got, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, expv);
        end
    endtask

    // Sink ready pattern, changed away from the clock edge.
    initial forever begin
        @(posedge clk);
        #2;
        tx_ready = !stall_on || (cyc % 3 != 0);
        cyc++;
    end

    // Collector, read counter and hold check (R11).
    initial begin
        bit prev_stall = 1'b0;
        logic [8:0] prev_w = '0;
        forever begin
            @(negedge clk);
            if (!rst_n) prev_stall = 1'b0;
            else begin
                if (prev_stall)
                    check(tx_valid && ({tx_is_cmd, tx_data} == prev_w), "R11",
                          "held byte", int'({tx_valid, tx_is_cmd, tx_data}), int'({1'b1, prev_w}));
                if (fb_rd_en) rd_cnt++;
                if (tx_valid && tx_ready) got_q.push_back({tx_is_cmd, tx_data});
                prev_stall = tx_valid && !tx_ready;
                prev_w     = {tx_is_cmd, tx_data};
            end
        end
    end

    // Reference stream built from the requirements.
    task automatic model(input vec_t v, input bit clr);
        int xa, xb, ya, yb, h, top, bot, np, w, cs, ce, ps, pe;
        h  = int'(v.h);
        xa = clr ? 0 : int'(v.x0);
        xb = clr ? DISP_W : int'(v.x1);
        ya = clr ? 0 : int'(v.y0);
        yb = clr ? h : int'(v.y1);
        top = (ya / 8) * 8;
        bot = ((yb + 7) / 8) * 8;
        if (bot > h) bot = h;
        np = (bot - top + 7) / 8;
        w  = xb - xa;
        cs = (int'(v.coff) + xa) & 255;
        ce = (cs + w - 1) & 255;
        ps = (int'(v.poff) + top / 8) & 255;
        pe = (ps + np - 1) & 255;
        exp_q.delete();
        if (!v.mode) begin
            if (!(m_cok && cs == m_cs && ce == m_ce)) begin
                exp_q.push_back({1'b1, 8'h21}); exp_q.push_back({1'b1, 8'(cs)});
                exp_q.push_back({1'b1, 8'(ce)});
                m_cok = 1'b1; m_cs = cs; m_ce = ce;
            end
            if (!(m_pok && ps == m_ps && pe == m_pe)) begin
                exp_q.push_back({1'b1, 8'h22}); exp_q.push_back({1'b1, 8'(ps)});
                exp_q.push_back({1'b1, 8'(pe)});
                m_pok = 1'b1; m_ps = ps; m_pe = pe;
            end
        end
        for (int i = 0; i < np; i++) begin
            if (v.mode) begin
                exp_q.push_back({1'b1, 8'hB0 | 8'((ps + i) & 7)});
                exp_q.push_back({1'b1, 8'(cs & 15)});
                exp_q.push_back({1'b1, 8'h10 | 8'(cs >> 4)});
            end
            for (int j = 0; j < w; j++) begin
                logic [7:0] b;
                int c;
                b = '0;
                c = xa + j;
                for (int k = 0; k < 8; k++) begin
                    int r;
                    r = top + 8 * i + k;
                    if (!clr && r < h) b[k] = fb[r * PITCH + c / 8][c % 8];
                end
                exp_q.push_back({1'b0, b});
            end
        end
    endtask

    task automatic run_req(input vec_t v, input bit clr, input string tag);
        int n;
        model(v, clr);
        got_q.delete();
        stall_on = v.stall;
        @(posedge clk);
        #2;
        rect_x0 = v.x0; rect_x1 = v.x1; rect_y0 = v.y0; rect_y1 = v.y1;
        disp_height = v.h; col_offset = v.coff; page_offset = v.poff;
        page_mode = v.mode; upd_req = !clr; clr_req = clr;
        rd_cnt = 0;
        @(posedge clk);
        #2;
        upd_req = 1'b0; clr_req = 1'b0;
        do @(negedge clk); while (busy);
        repeat (2) @(negedge clk);
        check(got_q.size() == exp_q.size(), tag, "stream length", got_q.size(), exp_q.size());
        n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
        for (int i = 0; i < n; i++)
            check(got_q[i] == exp_q[i], exp_q[i][8] ? (v.mode ? "R7" : "R5") : tag,
                  $sformatf("byte %0d", i), int'(got_q[i]), int'(exp_q[i]));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        m_cok = 1'b0; m_pok = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R10: idle after reset
        check(!tx_valid && !busy && !fb_rd_en, "R10", "idle outputs",
              int'({tx_valid, busy, fb_rd_en}), 0);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog R5: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        vec_t cv;
        do_reset();
        for (int i = 0; i < NV; i++) run_req(VECS[i], 1'b0, tag_of(i));

        // R9: clear in horizontal mode, no memory reads.
        cv = VECS[4];
        run_req(cv, 1'b1, "R9");
        check(rd_cnt == 0, "R9", "reads during clear", rd_cnt, 0);
        // R9: clear in page mode with stalls.
        cv = VECS[5];
        run_req(cv, 1'b1, "R9");
        check(rd_cnt == 0, "R9", "reads during page clear", rd_cnt, 0);

        // R10: same window after reset must resend both range commands.
        run_req(VECS[7], 1'b0, "R10");
        do_reset();
        run_req(VECS[7], 1'b0, "R10");
        check(got_q.size() > 0 && got_q[0] == {1'b1, 8'h21}, "R10", "first byte after reset",
              (got_q.size() > 0) ? int'(got_q[0]) : -1, int'({1'b1, 8'h21}));

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule